// File: doc/BRIEF.md
# Cascaded Audio Clock Divider Chain

This block derives a master audio clock and a serial bit clock from one source clock. It works entirely inside the source clock domain: every output is a registered one-cycle strobe or a level that changes on a source edge, so no derived clock is built from logic. The divided master path has three stages. A prescaler divides by 1 or by 8. A main divider divides by 1 to 256. A fixed toggle stage then halves the rate. Every divided master ratio is therefore even, from 2 up to 2 x 8 x 256 = 4096 source cycles.

A bypass request makes the master strobe fire on every source cycle, with no division. When the bypass is released, the chain restarts from a cleared count. A direction input chooses the source of the bit clock. The bit-clock divider (1 to 16) counts either the internally generated master strobe or a master strobe supplied from outside. In the second case the master output enable is withdrawn. New divider values are taken up only at a terminal count. Illegal values leave the previous setting in force.

A two-state mode machine controls the master path. DIVIDE is the state after reset; it runs the counters. BYPASS holds the counters cleared and emits a strobe every cycle. The transition GO_BYPASS (DIVIDE to BYPASS) is taken on an edge where `bypass_en` is high. The transition GO_DIVIDE (BYPASS to DIVIDE) is taken on an edge where `bypass_en` is low.

Top module: `audclk_div_chain`

## Requirements
- R1: While `rst_n` is low, `mclk_pulse`, `mclk_lvl` and `bclk_pulse` are 0. The first divided master strobe appears at the first rising edge after reset is released.
- R2: `pre8_sel` = 0 gives a prescale factor P of 1. `pre8_sel` = 1 gives P = 8.
- R3: `main_div_val` holds the main divisor M directly (1..256). In DIVIDE, master strobes are spaced 2 x P x M source cycles apart, so two strobes are never on consecutive cycles. The longest spacing is 4096.
- R4: In DIVIDE, `mclk_lvl` stays high for P x M cycles and then low for P x M cycles. `mclk_pulse` is high exactly in the first cycle of each high phase.
- R5: The cycle after `bypass_en` is sampled high, `mclk_pulse` is 1 on every cycle and `mclk_lvl` is 0. After `bypass_en` is sampled low, the chain restarts as it does after reset.
- R6: `mclk_oe` is the inverse of `mclk_dir_in`. When `mclk_dir_in` is 1, the bit divider counts `ext_mclk_strobe` instead of the internal master strobe.
- R7: `bit_div_val` holds the bit divisor B directly (1..16). `bclk_pulse` fires once for every B strobes counted, one cycle after the strobe that reaches the terminal count.
- R8: New values on `pre8_sel`, `main_div_val` and `bit_div_val` take effect only at the next terminal count of their stage. A period that is already running finishes at its old length.
- R9: A `main_div_val` of 0 or above 256 is ignored, and the previous M stays in force.
- R10: A `bit_div_val` of 0 or above 16 is ignored, and the previous B stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre8_sel | input | 1 | Prescaler select: 0 gives /1, 1 gives /8 |
| main_div_val | input | 9 | Main divisor M, legal 1..256 |
| bit_div_val | input | 5 | Bit divisor B, legal 1..16 |
| bypass_en | input | 1 | Request master strobe at the source rate |
| mclk_dir_in | input | 1 | 1: master clock comes from outside |
| ext_mclk_strobe | input | 1 | External master strobe, one cycle per period |
| mclk_pulse | output | 1 | Master clock strobe |
| mclk_lvl | output | 1 | Master clock square wave (divided mode) |
| mclk_oe | output | 1 | Master clock pad drive enable |
| bclk_pulse | output | 1 | Bit clock strobe |

## Verification
The master outputs change on the same rising edge at which the P x M count expires. A change of `bypass_en` shows one edge after it is sampled. A bit strobe follows the counted master strobe by one edge, so an internally sourced bit clock trails the source cycle by two registers. The bench steps a behavioural model on each rising edge, using the inputs held since the previous falling edge. It compares every output against that model on each falling edge, so each latency is checked in the exact cycle where it is due.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
    typedef enum logic [0:0] {
        MODE_DIVIDE = 1'b0,
        MODE_BYPASS = 1'b1
    } chain_mode_e;
endpackage

// File: rtl/audclk_prescale.sv
module audclk_prescale #(
    parameter int PRE_DIV = 8,
    localparam int CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sel_div,
    output logic tick
);
    localparam logic [CW-1:0] TOP = CW'(PRE_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= sel_div ? TOP : '0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/audclk_main_div.sv
module audclk_main_div #(
    parameter int MAX_DIV = 256,
    localparam int CW = $clog2(MAX_DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          step,
    input  logic [CW-1:0] reload,
    output logic          terminal,
    output logic          lvl,
    output logic          pulse
);
    logic [CW-1:0] cnt_q;

    // a half period ends when a prescaler tick meets an exhausted count
    assign terminal = step && (cnt_q == '0) && !hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl   <= 1'b0;
            pulse <= 1'b0;
        end else if (hold) begin
            cnt_q <= '0;
            lvl   <= 1'b0;
            pulse <= 1'b1;
        end else if (terminal) begin
            cnt_q <= reload;
            lvl   <= ~lvl;
            pulse <= ~lvl;
        end else begin
            if (step) begin
                cnt_q <= cnt_q - 1'b1;
            end
            pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/audclk_bit_div.sv
module audclk_bit_div #(
    parameter int MAX_DIV = 16,
    localparam int VW = $clog2(MAX_DIV + 1),
    localparam int CW = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic [VW-1:0] div_val,
    output logic          pulse
);
    logic [VW-1:0] act_q;
    logic [CW-1:0] cnt_q;
    logic          val_ok;
    logic [VW-1:0] eff;

    assign val_ok = (div_val != '0) && (div_val <= VW'(MAX_DIV));
    assign eff    = val_ok ? div_val : act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= VW'(1);
            cnt_q <= '0;
            pulse <= 1'b0;
        end else if (strobe && (cnt_q == '0)) begin
            act_q <= eff;
            cnt_q <= CW'(eff - VW'(1));
            pulse <= 1'b1;
        end else begin
            if (strobe) begin
                cnt_q <= cnt_q - 1'b1;
            end
            pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/audclk_div_chain.sv
module audclk_div_chain
    import audclk_pkg::*;
#(
    parameter int PRE_DIV  = 8,
    parameter int MAIN_MAX = 256,
    parameter int BIT_MAX  = 16,
    localparam int MVW = $clog2(MAIN_MAX + 1),
    localparam int BVW = $clog2(BIT_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre8_sel,
    input  logic [MVW-1:0] main_div_val,
    input  logic [BVW-1:0] bit_div_val,
    input  logic           bypass_en,
    input  logic           mclk_dir_in,
    input  logic           ext_mclk_strobe,
    output logic           mclk_pulse,
    output logic           mclk_lvl,
    output logic           mclk_oe,
    output logic           bclk_pulse
);
    localparam int MCW = $clog2(MAIN_MAX);

    chain_mode_e    mode_q, mode_d;
    logic           hold;
    logic           pre_tick;
    logic           half_tick;
    logic           act_pre8_q;
    logic [MVW-1:0] act_main_q;
    logic           main_ok;
    logic [MVW-1:0] main_eff;
    logic           pre_eff;
    logic [MCW-1:0] main_reload;
    logic           bit_strobe;

    // next-state: GO_BYPASS and GO_DIVIDE
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_DIVIDE: if (bypass_en)  mode_d = MODE_BYPASS;
            MODE_BYPASS: if (!bypass_en) mode_d = MODE_DIVIDE;
            default:                     mode_d = MODE_DIVIDE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_DIVIDE;
        else        mode_q <= mode_d;
    end

    // state outputs
    always_comb begin
        hold = 1'b0;
        unique case (mode_q)
            MODE_DIVIDE: hold = 1'b0;
            MODE_BYPASS: hold = 1'b1;
            default:     hold = 1'b0;
        endcase
    end

    // settings are adopted only when a half period closes
    assign main_ok     = (main_div_val != '0) && (main_div_val <= MVW'(MAIN_MAX));
    assign main_eff    = main_ok ? main_div_val : act_main_q;
    assign pre_eff     = half_tick ? pre8_sel : act_pre8_q;
    assign main_reload = MCW'(main_eff - MVW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_pre8_q <= 1'b0;
            act_main_q <= MVW'(1);
        end else if (half_tick) begin
            act_pre8_q <= pre8_sel;
            act_main_q <= main_eff;
        end
    end

    audclk_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hold),
        .sel_div (pre_eff),
        .tick    (pre_tick)
    );

    audclk_main_div #(.MAX_DIV(MAIN_MAX)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .step     (pre_tick),
        .reload   (main_reload),
        .terminal (half_tick),
        .lvl      (mclk_lvl),
        .pulse    (mclk_pulse)
    );

    assign bit_strobe = mclk_dir_in ? ext_mclk_strobe : mclk_pulse;
    assign mclk_oe    = ~mclk_dir_in;

    audclk_bit_div #(.MAX_DIV(BIT_MAX)) u_bit (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (bit_strobe),
        .div_val (bit_div_val),
        .pulse   (bclk_pulse)
    );
endmodule

// File: rtl/audclk_div_chain_chk.sv
module audclk_div_chain_chk (
    input logic clk,
    input logic rst_n,
    input logic byp_st,
    input logic mclk_pulse,
    input logic mclk_lvl,
    input logic bclk_pulse,
    input logic mclk_dir_in,
    input logic ext_mclk_strobe
);
    // R4: every rise of the square wave carries the strobe
    assert_mclk_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mclk_lvl) |-> mclk_pulse);

    // R3: in divided operation strobes are at least two cycles apart
    assert_no_double_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(byp_st) && !$past(byp_st, 2) && $past(mclk_pulse)) |-> !mclk_pulse);

    // R5: a bypass cycle yields a strobe and a low level on the next edge
    assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(byp_st) |-> (mclk_pulse && !mclk_lvl));

    // R7: a bit strobe needs a counted master strobe one edge earlier
    assert_bclk_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_pulse |-> $past(mclk_dir_in ? ext_mclk_strobe : mclk_pulse));
endmodule

bind audclk_div_chain audclk_div_chain_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .byp_st          (hold),
    .mclk_pulse      (mclk_pulse),
    .mclk_lvl        (mclk_lvl),
    .bclk_pulse      (bclk_pulse),
    .mclk_dir_in     (mclk_dir_in),
    .ext_mclk_strobe (ext_mclk_strobe)
);

// File: tb/audclk_div_chain_bench.sv
module audclk_div_chain_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre8_sel = 1'b0;
    logic [8:0] main_div_val = 9'd3;
    logic [4:0] bit_div_val = 5'd1;
    logic       bypass_en = 1'b0;
    logic       mclk_dir_in = 1'b0;
    logic       ext_mclk_strobe = 1'b0;
    logic       mclk_pulse, mclk_lvl, mclk_oe, bclk_pulse;

    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // behavioural reference state
    int m_byp, m_left, m_lvl, m_pulse, m_p, m_m;
    int b_left, b_act, b_pulse;

    always #(CLK_PERIOD / 2) clk = ~clk;

    audclk_div_chain u_audclk_div_chain (
        .clk             (clk),
        .rst_n           (rst_n),
        .pre8_sel        (pre8_sel),
        .main_div_val    (main_div_val),
        .bit_div_val     (bit_div_val),
        .bypass_en       (bypass_en),
        .mclk_dir_in     (mclk_dir_in),
        .ext_mclk_strobe (ext_mclk_strobe),
        .mclk_pulse      (mclk_pulse),
        .mclk_lvl        (mclk_lvl),
        .mclk_oe         (mclk_oe),
        .bclk_pulse      (bclk_pulse)
    );

    always @(posedge clk) begin : model
        int s;
        if (!rst_n) begin
            m_byp = 0; m_left = 0; m_lvl = 0; m_pulse = 0; m_p = 1; m_m = 1;
            b_left = 0; b_act = 1; b_pulse = 0;
        end else begin
            s = mclk_dir_in ? int'(ext_mclk_strobe) : m_pulse;
            if (m_byp != 0) begin
                m_pulse = 1; m_lvl = 0; m_left = 0;
            end else if (m_left == 0) begin
                m_pulse = (m_lvl == 0) ? 1 : 0;
                m_lvl = 1 - m_lvl;
                if (main_div_val >= 1 && main_div_val <= 256) m_m = int'(main_div_val);
                m_p = pre8_sel ? 8 : 1;
                m_left = m_p * m_m - 1;
            end else begin
                m_left = m_left - 1;
                m_pulse = 0;
            end
            m_byp = int'(bypass_en);
            if (s != 0 && b_left == 0) begin
                if (bit_div_val >= 1 && bit_div_val <= 16) b_act = int'(bit_div_val);
                b_left = b_act - 1;
                b_pulse = 1;
            end else begin
                if (s != 0) b_left = b_left - 1;
                b_pulse = 0;
            end
        end
    end

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            string tag;
            tag = rst_n ? cur_tag : "R1";
            check(tag, "mclk_pulse", mclk_pulse, logic'(m_pulse != 0));
            check(tag, "mclk_lvl", mclk_lvl, logic'(m_lvl != 0));
            check(tag, "bclk_pulse", bclk_pulse, logic'(b_pulse != 0));
            check("R6", "mclk_oe", mclk_oe, !mclk_dir_in);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual expired expected completion");
        finish_run();
    end

    initial begin
        run(4);
        rst_n = 1'b1;
        cur_tag = "R1"; run(10);
        cur_tag = "R3"; main_div_val = 9'd1; run(20);
        main_div_val = 9'd3; run(40);
        cur_tag = "R2"; pre8_sel = 1'b1; main_div_val = 9'd2; run(100);
        cur_tag = "R3"; main_div_val = 9'd256; run(17000);
        cur_tag = "R4"; pre8_sel = 1'b0; main_div_val = 9'd5; run(4200);
        cur_tag = "R8"; main_div_val = 9'd7; run(5);
        main_div_val = 9'd2; run(60);
        pre8_sel = 1'b1; run(3);
        pre8_sel = 1'b0; run(80);
        cur_tag = "R9"; main_div_val = 9'd0; run(40);
        main_div_val = 9'd300; run(40);
        cur_tag = "R5"; bypass_en = 1'b1; run(12);
        bypass_en = 1'b0; run(30);
        cur_tag = "R7"; main_div_val = 9'd1; bit_div_val = 5'd3; run(60);
        bit_div_val = 5'd16; run(200);
        bit_div_val = 5'd1; run(20);
        cur_tag = "R10"; bit_div_val = 5'd0; run(40);
        bit_div_val = 5'd20; run(40);
        cur_tag = "R6"; mclk_dir_in = 1'b1; bit_div_val = 5'd2;
        for (int k = 0; k < 60; k++) begin
            ext_mclk_strobe = (k % 3 == 0);
            run(1);
        end
        ext_mclk_strobe = 1'b0; mclk_dir_in = 1'b0; run(20);
        finish_run();
    end
endmodule